// File: doc/BRIEF.md
# Packed Byte Permute and Align Unit

This block is a 128-bit datapath that works on sixteen byte lanes and has two operations. An opcode input picks the operation. In permute mode, each output byte is taken from operand A. The control byte in the same lane of operand B chooses which byte. In align mode, A and B are joined into a 32-byte value, shifted right by a byte count from an 8-bit immediate, and the low sixteen bytes are kept.

The operands, opcode and immediate are sampled together while the input valid flag is high. The result appears one clock later in an output register, along with an output valid flag. The result register keeps its value in cycles with no valid input. Byte 0 is bits [7:0] of every 128-bit bus. Byte k is bits [8k+7:8k].

Top module: `byte_perm_align`

## Requirements
- R1: With op_align low, output byte i equals byte j of src_a, where j is bits [3:0] of byte i of src_b, provided bit 7 of that control byte is clear.
- R2: With op_align low, any output byte whose control byte has bit 7 set is zero, whatever the other seven bits hold.
- R3: With op_align low, control bits [6:4] have no effect: setting them to any value on control bytes with bit 7 clear gives the same result.
- R4: With op_align high, src_a forms bytes 16..31 and src_b forms bytes 0..15 of a 32-byte value. Output byte i is byte N+i of that value, where N is shift_imm. For example, N=15 gives src_b byte 15 in lane 0, followed by src_a bytes 0..14.
- R5: With op_align high, N=0 returns src_b unchanged and N=16 returns src_a unchanged.
- R6: With op_align high and N from 17 to 32, the result is src_a shifted right by N-16 bytes, with zero bytes filling the top lanes. N=32 gives all zeros.
- R7: With op_align high and N above 32 (up to 255), the result is all zeros.
- R8: A synchronous active-low reset clears result and out_valid at the next clock edge.
- R9: out_valid equals in_valid from the previous clock edge, so the latency is exactly one cycle.
- R10: In a cycle where in_valid is low, result holds its previous value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands, opcode and immediate are valid this cycle |
| op_align | input | 1 | 0 = byte permute, 1 = two-operand byte align |
| src_a | input | 128 | Permute source bytes; upper half of the align pair |
| src_b | input | 128 | Permute control bytes; lower half of the align pair |
| shift_imm | input | 8 | Align shift in bytes, unsigned |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 128 | Registered result |

## Verification
Permute is driven three ways: with distinct ascending source bytes, so that every selected index can be read straight from the output; with control bytes that have bit 7 mixed in, which shows forced-zero lanes apart from selected lanes; and again with +32 added to each clear control byte, which shows whether bits [6:4] leak into the index. Align is swept over the region boundaries 0, 15, 16, 17, 31, 32, 33 and 255, with distinct bytes in both operands. A wrong region decode therefore shows up as a misplaced byte rather than a coincidental match. Random operands, opcodes and shift values, weighted toward 0..40, are interleaved with idle cycles that carry random garbage. These idle cycles check that the result holds.

// File: rtl/bpa_pkg.sv
// Package: shared widths and opcode type for the byte permute/align unit.
// Assumes byte lanes are 8 bits and lane 0 sits in the least significant bits.
package bpa_pkg;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned LANES    = 16;
    localparam int unsigned VEC_W    = BYTE_W * LANES;
    localparam int unsigned IDX_W    = $clog2(LANES);
    localparam int unsigned SHAMT_W  = 8;

    typedef enum logic {
        OP_PERMUTE = 1'b0,
        OP_ALIGN   = 1'b1
    } bpa_op_e;

    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/bpa_permute.sv
// Module: per-lane byte selector. Each output byte copies the src byte indexed
// by the low index bits of its control byte. It is forced to zero when the
// control byte's top bit is set. The middle control bits are never read.
// Assumes LANES is a power of two.
module bpa_permute #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned LANES  = 16
) (
    input  logic [BYTE_W*LANES-1:0] src,
    input  logic [BYTE_W*LANES-1:0] ctl,
    output logic [BYTE_W*LANES-1:0] dst
);
    localparam int unsigned IDX_W = $clog2(LANES);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] cbyte;
        logic [IDX_W-1:0]  sel;
        assign cbyte = ctl[g*BYTE_W +: BYTE_W];
        assign sel   = cbyte[IDX_W-1:0];
        // Pick the indexed source byte, or zero on the force-zero bit.
        always_comb begin
            if (cbyte[BYTE_W-1])
                dst[g*BYTE_W +: BYTE_W] = '0;
            else
                dst[g*BYTE_W +: BYTE_W] = src[sel*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/bpa_align.sv
// Module: two-operand byte align. It treats {hi, lo} as one 2*LANES-byte value,
// shifts it right by shamt bytes, and keeps the low LANES bytes. Any lane whose
// source position lies past the top of the pair reads zero. This covers both the
// partial zero-fill region and the all-zero region.
// Assumes shamt is unsigned.
module bpa_align #(
    parameter int unsigned BYTE_W  = 8,
    parameter int unsigned LANES   = 16,
    parameter int unsigned SHAMT_W = 8
) (
    input  logic [BYTE_W*LANES-1:0] hi,
    input  logic [BYTE_W*LANES-1:0] lo,
    input  logic [SHAMT_W-1:0]      shamt,
    output logic [BYTE_W*LANES-1:0] dst
);
    localparam int unsigned PAIR   = 2 * LANES;
    localparam int unsigned PIDX_W = $clog2(PAIR);
    localparam int unsigned POS_W  = SHAMT_W + 2;

    logic [2*BYTE_W*LANES-1:0] pair;
    assign pair = {hi, lo};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [POS_W-1:0] pos;
        assign pos = POS_W'(shamt) + POS_W'(g);
        // Select byte pos of the pair, or zero past its top.
        always_comb begin
            if (pos < POS_W'(PAIR))
                dst[g*BYTE_W +: BYTE_W] = pair[pos[PIDX_W-1:0]*BYTE_W +: BYTE_W];
            else
                dst[g*BYTE_W +: BYTE_W] = '0;
        end
    end
endmodule

// File: rtl/byte_perm_align.sv
// Module: top of the byte permute/align unit. It computes both operations in
// parallel, selects one by opcode, and registers the selection with one cycle
// of latency. The result register loads only on valid input. Reset is
// synchronous and active low.
module byte_perm_align
    import bpa_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               op_align,
    input  logic [VEC_W-1:0]   src_a,
    input  logic [VEC_W-1:0]   src_b,
    input  logic [SHAMT_W-1:0] shift_imm,
    output logic               out_valid,
    output logic [VEC_W-1:0]   result
);
    bpa_op_e          op;
    logic [VEC_W-1:0] perm_q;
    logic [VEC_W-1:0] algn_q;
    logic [VEC_W-1:0] nxt;

    assign op = bpa_op_e'(op_align);

    bpa_permute #(.BYTE_W(BYTE_W), .LANES(LANES)) u_perm (
        .src (src_a),
        .ctl (src_b),
        .dst (perm_q)
    );

    bpa_align #(.BYTE_W(BYTE_W), .LANES(LANES), .SHAMT_W(SHAMT_W)) u_algn (
        .hi    (src_a),
        .lo    (src_b),
        .shamt (shift_imm),
        .dst   (algn_q)
    );

    // Choose the operation's result by opcode.
    always_comb begin
        unique case (op)
            OP_ALIGN: nxt = algn_q;
            default:  nxt = perm_q;
        endcase
    end

    // Output register: clear on reset, load on valid input, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                result <= nxt;
        end
    end
endmodule

// Checker: properties over the top module's ports.
module bpa_chk
    import bpa_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               op_align,
    input logic [VEC_W-1:0]   src_a,
    input logic [VEC_W-1:0]   src_b,
    input logic [SHAMT_W-1:0] shift_imm,
    input logic               out_valid,
    input logic [VEC_W-1:0]   result
);
    logic all_kill;
    // Every control byte has its force-zero bit set.
    always_comb begin
        all_kill = 1'b1;
        for (int i = 0; i < LANES; i++)
            all_kill = all_kill & src_b[i*BYTE_W + BYTE_W - 1];
    end

    // R8
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));

    // R9
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    // R5
    zero_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_align && shift_imm == 8'd0) |=> result == $past(src_b));

    // R5
    lane_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_align && shift_imm == 8'd16) |=> result == $past(src_a));

    // R7
    far_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_align && shift_imm > 8'd32) |=> result == '0);

    // R2
    all_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_align && all_kill) |=> result == '0);
endmodule

bind byte_perm_align bpa_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_align  (op_align),
    .src_a     (src_a),
    .src_b     (src_b),
    .shift_imm (shift_imm),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/sim_byte_perm_align.sv
module sim_byte_perm_align;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         op_align = 1'b0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [7:0]   shift_imm = '0;
    logic         out_valid;
    logic [127:0] result;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    byte_perm_align u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_align(op_align),
        .src_a(src_a), .src_b(src_b), .shift_imm(shift_imm),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [127:0] ref_perm(input logic [127:0] a, input logic [127:0] b);
        logic [127:0] r = '0;
        for (int i = 0; i < 16; i++) begin
            logic [7:0] c = b[i*8 +: 8];
            if (!c[7]) r[i*8 +: 8] = a[int'(c[3:0])*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [127:0] ref_align(input logic [127:0] a, input logic [127:0] b, input logic [7:0] n);
        logic [127:0] r = '0;
        for (int i = 0; i < 16; i++) begin
            int k = int'(n) + i;
            if (k < 16)      r[i*8 +: 8] = b[k*8 +: 8];
            else if (k < 32) r[i*8 +: 8] = a[(k-16)*8 +: 8];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Issue one operation, then check the result one cycle later.
    task automatic run_op(input string req, input logic al, input logic [127:0] a,
                          input logic [127:0] b, input logic [7:0] n);
        logic [127:0] exp = al ? ref_align(a, b, n) : ref_perm(a, b);
        @(negedge clk);
        in_valid = 1'b1; op_align = al; src_a = a; src_b = b; shift_imm = n;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, result, exp);
        check({req, " valid (R9)"}, {127'd0, out_valid}, 128'd1);
    endtask

    // Idle cycle with garbage inputs: the result must hold (R10).
    task automatic idle_garbage();
        logic [127:0] held = result;
        @(negedge clk);
        in_valid = 1'b0; op_align = 1'($urandom);
        src_a = {$urandom, $urandom, $urandom, $urandom};
        src_b = {$urandom, $urandom, $urandom, $urandom};
        shift_imm = 8'($urandom);
        @(negedge clk);
        check("R10 hold", result, held);
        check("R9 no valid", {127'd0, out_valid}, 128'd0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [127:0] seq_a, seq_b, ctl, ctl32;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 16; i++) begin
            seq_a[i*8 +: 8] = 8'(i + 1);
            seq_b[i*8 +: 8] = 8'(8'h80 + i);
        end
        repeat (3) @(negedge clk);
        check("R8 reset result", result, '0);
        check("R8 reset valid", {127'd0, out_valid}, 128'd0);
        rst_n = 1'b1;

        // R1: plain index selection, all bit7 clear
        ctl = '0;
        for (int i = 0; i < 16; i++) ctl[i*8 +: 8] = 8'((i * 7 + 3) % 16);
        run_op("R1 permute", 1'b0, seq_a, ctl, 8'd0);
        check("R1 lane0 picks byte 3", {120'd0, result[7:0]}, 128'd4);
        // R2: mix in force-zero lanes
        ctl[15:8] = 8'h80; ctl[47:40] = 8'hFF; ctl[127:120] = 8'h8C;
        run_op("R2 zero lanes", 1'b0, seq_a, ctl, 8'd0);
        check("R2 lane1 zero", {120'd0, result[15:8]}, 128'd0);
        run_op("R2 all zero", 1'b0, seq_a, {16{8'h85}}, 8'd0);
        check("R2 all zero direct", result, '0);
        // R3: add 32 (and 0x70) to clear control bytes, result unchanged
        ctl32 = ctl;
        for (int i = 0; i < 16; i++)
            if (!ctl[i*8+7]) ctl32[i*8 +: 8] = ctl[i*8 +: 8] + 8'd32;
        run_op("R3 +32", 1'b0, seq_a, ctl32, 8'd0);
        check("R3 same as base", result, ref_perm(seq_a, ctl));
        for (int i = 0; i < 16; i++)
            if (!ctl[i*8+7]) ctl32[i*8 +: 8] = ctl[i*8 +: 8] | 8'h70;
        run_op("R3 bits 6:4 set", 1'b0, seq_a, ctl32, 8'd0);
        check("R3 same as base 2", result, ref_perm(seq_a, ctl));

        // Align boundaries
        run_op("R5 N=0", 1'b1, seq_a, seq_b, 8'd0);
        check("R5 N=0 is B", result, seq_b);
        run_op("R5 N=16", 1'b1, seq_a, seq_b, 8'd16);
        check("R5 N=16 is A", result, seq_a);
        run_op("R4 N=15", 1'b1, seq_a, seq_b, 8'd15);
        check("R4 N=15 lane0", {120'd0, result[7:0]}, 128'h8F);
        run_op("R4 N=5", 1'b1, seq_a, seq_b, 8'd5);
        run_op("R6 N=17", 1'b1, seq_a, seq_b, 8'd17);
        check("R6 N=17 top zero", {120'd0, result[127:120]}, 128'd0);
        check("R6 N=17 lane0", {120'd0, result[7:0]}, 128'd2);
        run_op("R6 N=31", 1'b1, seq_a, seq_b, 8'd31);
        run_op("R6 N=32", 1'b1, seq_a, seq_b, 8'd32);
        check("R6 N=32 zero", result, '0);
        run_op("R7 N=33", 1'b1, seq_a, seq_b, 8'd33);
        check("R7 N=33 zero", result, '0);
        run_op("R7 N=255", 1'b1, seq_a, seq_b, 8'd255);
        idle_garbage();

        // Random mix
        for (int t = 0; t < 300; t++) begin
            logic al = 1'($urandom);
            logic [7:0] n = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 41);
            logic [127:0] a = {$urandom, $urandom, $urandom, $urandom};
            logic [127:0] b = {$urandom, $urandom, $urandom, $urandom};
            run_op(al ? "R4 R6 R7 random align" : "R1 R2 random permute", al, a, b, n);
            if (t % 10 == 0) idle_garbage();
        end

        // R8: reset mid-stream clears state
        run_op("R1 pre-reset", 1'b0, seq_a, ctl, 8'd0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R8 mid reset result", result, '0);
        check("R8 mid reset valid", {127'd0, out_valid}, 128'd0);
        rst_n = 1'b1;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule